// File: doc/BRIEF.md
# Cascaded Dual-Stage Clock Divider with 2.5 Prescale

This block derives a slow clock-enable pulse from a fast input clock. Two integer counting stages are chained, and each divides by its 3-bit configuration field plus one. An optional fixed prescale stage in front of them stretches the overall ratio by a further factor of 2.5. The input clock ticks, the enable output pulses for one cycle once per divided period, and logic downstream uses that pulse as its clock enable.

The three divide settings are sampled together at the end of every complete output period. Software can therefore rewrite them at any time without causing a short or torn period. A separate gate input is not sampled this way. It masks the output at once while the counters keep running. With both fields at zero and the prescale off, the output pulses on every input cycle.

Top module: `cascade_clk_div`

## Requirements
- R1: The first stage counts prescaled ticks and divides them by `div_a_i + 1`.
- R2: The second stage counts wraps of the first stage and divides them by `div_b_i + 1`. With the prescale off, every output period is exactly `(div_a_i+1)*(div_b_i+1)` input cycles.
- R3: Each field is 3 bits wide, so one stage divides by at most 8. Both fields at 7 give the largest integer ratio, 64.
- R4: With `slow_i` = 1 the total ratio R is multiplied by 2.5. Each output period is either floor(5R/2) or ceil(5R/2) cycles. Any two consecutive periods add up to exactly 5R cycles. Two output pulses are never adjacent.
- R5: While `gate_i` = 0 the output is 0 from the next cycle on. When `gate_i` returns to 1, pulses resume at the configured ratio.
- R6: New values on `div_a_i`, `div_b_i` and `slow_i` take effect only after the output period in progress has completed with the old values.
- R7: With both fields 0, `slow_i` = 0 and `gate_i` = 1, `tick_o` is 1 on every cycle.
- R8: `rst_i` is a synchronous reset. It clears all counters and the stored setting, and `tick_o` is 0 on every cycle after an edge at which `rst_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| div_a_i | input | 3 | First-stage field (divide by value + 1) |
| div_b_i | input | 3 | Second-stage field (divide by value + 1) |
| slow_i | input | 1 | 1 enables the extra divide-by-2.5 |
| gate_i | input | 1 | 1 lets pulses out, 0 holds the output low |
| tick_o | output | 1 | One-cycle enable pulse per divided period |

## Verification
The bench measures the spacing between output pulses, not their absolute times.

- **Random settings.** Randomly drawn field pairs, with and without the prescale, show whether the two stages multiply rather than add. The alternating floor/ceil pattern and its pair sum expose a prescale that drifts or rounds in only one direction.
- **Directed corner cases.**
  - Divide-by-1 and divide-by-64 (with and without the prescale) cover the extreme counter values.
  - A mid-period setting change shows whether the stored setting is loaded early.
  - Toggling the gate shows whether the output is masked at once and whether the counters run on.
  - A reset asserted mid-run confirms the output goes low.

// File: rtl/cascade_clk_div.sv
module cascade_clk_div #(
  parameter int FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [FW-1:0] div_a_i,
  input  logic [FW-1:0] div_b_i,
  input  logic          slow_i,
  input  logic          gate_i,
  output logic          tick_o
);

  logic [FW-1:0] cur_a, cur_b, cnt_a, cnt_b;
  logic          cur_p;
  logic [1:0]    pc;
  logic          ph;
  logic          tick_q;

  // prescale tick: every cycle, or alternating 2/3-cycle spacing
  wire pre_tick   = !cur_p || (pc == (ph ? 2'd2 : 2'd1));
  wire wrap_a     = pre_tick && (cnt_a == cur_a);
  wire period_end = wrap_a && (cnt_b == cur_b);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_a  <= '0;
      cur_b  <= '0;
      cur_p  <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
      pc     <= 2'd0;
      ph     <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (!cur_p) begin
        pc <= 2'd0;
        ph <= 1'b0;
      end else if (pre_tick) begin
        pc <= 2'd0;
        ph <= ~ph;
      end else begin
        pc <= pc + 2'd1;
      end

      if (pre_tick) cnt_a <= wrap_a ? '0 : cnt_a + FW'(1);
      if (wrap_a)   cnt_b <= (cnt_b == cur_b) ? '0 : cnt_b + FW'(1);

      if (period_end) begin
        cur_a <= div_a_i;
        cur_b <= div_b_i;
        cur_p <= slow_i;
      end

      tick_q <= gate_i && period_end;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/cascade_clk_div_chk.sv
module cascade_clk_div_chk #(
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          gate,
  input logic          tick,
  input logic [FW-1:0] cur_a,
  input logic [FW-1:0] cur_b,
  input logic          cur_p,
  input logic [FW-1:0] cnt_a,
  input logic [FW-1:0] cnt_b
);

  assert_reset_quiet_R8: assert property (@(posedge clk) rst |=> !tick);

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !tick);

  assert_div_one_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_a == '0 && cur_b == '0 && !cur_p && gate) |=> tick);

  assert_pre_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_p && tick) |=> !tick);

  assert_stage_a_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_a <= cur_a);

  assert_stage_b_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_b <= cur_b);

endmodule

bind cascade_clk_div cascade_clk_div_chk #(.FW(FW)) u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .gate  (gate_i),
  .tick  (tick_o),
  .cur_a (cur_a),
  .cur_b (cur_b),
  .cur_p (cur_p),
  .cnt_a (cnt_a),
  .cnt_b (cnt_b)
);

// File: tb/test_cascade_clk_div.sv
`timescale 1ns/1ps
module test_cascade_clk_div;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] da = '0, db = '0;
  logic       sl = 1'b0, gt = 1'b1;
  logic       tick;
  int         cyc = 0;
  int         errors = 0;
  int         checks = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cascade_clk_div #(.FW(3)) i_cascade_clk_div (
    .clk_i(clk), .rst_i(rst), .div_a_i(da), .div_b_i(db),
    .slow_i(sl), .gate_i(gt), .tick_o(tick)
  );

  function automatic int ratio(input int a, input int b);
    return (a + 1) * (b + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_pulse(output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 1000);
    if (!tick) begin
      chk(1'b0, "watchdog pulse", n, 0);
      finish_run();
    end
    t = cyc;
  endtask

  task automatic apply(input int a, input int b, input bit p);
    @(negedge clk);
    da = 3'(a); db = 3'(b); sl = p;
  endtask

  task automatic run_cfg(input int a, input int b, input bit p, input string req);
    int t, tp, r, lo, hi, prev;
    int iv[4];
    apply(a, b, p);
    wait_pulse(t);
    wait_pulse(tp);
    for (int k = 0; k < 4; k++) begin
      wait_pulse(t);
      iv[k] = t - tp;
      tp = t;
    end
    r = ratio(a, b);
    if (!p) begin
      for (int k = 0; k < 4; k++) chk(iv[k] == r, req, iv[k], r);
    end else begin
      lo = (5 * r) / 2;
      hi = (5 * r + 1) / 2;
      prev = iv[0];
      chk(iv[0] == lo || iv[0] == hi, {req, " R4 period"}, iv[0], lo);
      for (int k = 1; k < 4; k++) begin
        chk(iv[k] == lo || iv[k] == hi, {req, " R4 period"}, iv[k], lo);
        chk(prev + iv[k] == 5 * r, {req, " R4 pair"}, prev + iv[k], 5 * r);
        prev = iv[k];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog global", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, t2, cnt;
    void'($urandom(32'd4242));

    // R8: output low during reset
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(tick == 1'b0, "R8 reset low", tick, 0);
    end
    @(negedge clk) rst = 1'b0;

    // R7: divide by one
    apply(0, 0, 0);
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    chk(cnt == 20, "R7 every cycle", cnt, 20);

    // R1 / R2 / R3 directed
    run_cfg(5, 0, 0, "R1 first stage");
    run_cfg(0, 6, 0, "R2 second stage");
    run_cfg(2, 3, 0, "R2 cascade");
    run_cfg(7, 7, 0, "R3 max 64");
    run_cfg(7, 7, 1, "R3 max with prescale");
    run_cfg(0, 0, 1, "R4 ratio 1");
    run_cfg(2, 0, 1, "R4 ratio 3");

    // random settings
    for (int k = 0; k < 12; k++) begin
      int a = int'($urandom_range(7, 0));
      int b = int'($urandom_range(7, 0));
      bit p = 1'($urandom_range(1, 0));
      run_cfg(a, b, p, "R2 random");
    end

    // R6: change mid-period applies after the current period
    apply(7, 0, 0);
    wait_pulse(t0);
    wait_pulse(t0);
    repeat (2) @(negedge clk);
    da = 3'd1; db = 3'd0; sl = 1'b0;
    wait_pulse(t1);
    wait_pulse(t2);
    chk(t1 - t0 == 8, "R6 old period kept", t1 - t0, 8);
    chk(t2 - t1 == 2, "R6 new period used", t2 - t1, 2);

    // R5: gate
    apply(1, 1, 0);
    wait_pulse(t0);
    wait_pulse(t0);
    @(negedge clk) gt = 1'b0;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    chk(cnt == 0, "R5 gated low", cnt, 0);
    gt = 1'b1;
    wait_pulse(t1);
    wait_pulse(t2);
    chk(t2 - t1 == 4, "R5 resumed ratio", t2 - t1, 4);

    // R8: reset mid-run
    apply(0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0, "R8 reset clears", tick, 0);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick == 1'b1, "R8 restart divide by one", tick, 1);

    finish_run();
  end

endmodule